// File: doc/BRIEF.md
# Virtually-Indexed Physically-Tagged L1 Lookup Front End

This block sits between a load/store unit and a small L1 data cache. A request arrives with a virtual address. In the lookup cycle two things happen at once. The cache set is selected using only the page-offset bits, which translation never changes. A small fully associative translation buffer maps the virtual page number to a physical frame number. When both results are ready, the stored physical tag of every way is compared with the translated frame number.

A translation-buffer miss stalls the access, with no hit or miss result, until a matching entry is written through the refill port. The lookup is then replayed. Refilled entries carry a page-valid bit and read and write permission bits. An access to an invalid page, or one the permissions forbid, ends with a fault.

A read that misses in the cache raises a miss request carrying the physical line address. The block stays busy until one line-fill beat arrives and is written into a victim way. It then replays the access, which completes as a hit. Write hits merge the enabled bytes into the line. Write misses are reported and do not allocate a line.

Top module: `vipt_l1_lookup`

## Requirements
- R1: Pages are 4 KiB. Address bits [11:0] of every completed response's physical address equal bits [11:0] of the request's virtual address. The set index is virtual bits [11:6], the line offset is bits [5:0], and the 32-bit word within the line is selected by bits [5:2].
- R2: Physical address bits [31:12] are the frame number held by the translation-buffer entry whose page number equals virtual bits [31:12]. The stored tag of each way is compared against that frame number.
- R3: When no translation-buffer entry matches, the access stalls. reqReady stays low, and no response or miss request appears until a refill is written. The access then replays.
- R4: If the matching entry's page-valid bit is clear, the access completes with rspFault set, rspHit and rspMiss clear, and no miss request.
- R5: Permission bit 0 allows reads and permission bit 1 allows writes. An access whose kind is not allowed completes with rspFault.
- R6: A read cache miss holds missReq high, with missPaddr = {frame, index, 6'b0}, until lineFillValid. The filled line is then written, and the replayed read completes with rspHit and the requested word from the filled line. Fill word w (w = 0..15) is lineFillData[32w+31:32w].
- R7: A write hit completes with rspHit and replaces exactly the bytes enabled in reqBe (bit b covers data bits [8b+7:8b]) of the addressed word. Later reads return the merged word.
- R8: A write miss completes with rspMiss and the physical address, and does not allocate. A later read of the same line still raises a miss request.
- R9: A line fill goes to the lowest-numbered invalid way of the set. When all 4 ways are valid, it goes to a round-robin way pointer, which starts at 0 and advances after each such eviction.
- R10: The translation buffer holds 8 entries. A refill whose page number is already present overwrites that entry in place. Any other refill writes the slot under a round-robin pointer, which starts at 0 and then advances. At most one entry ever matches a lookup.
- R11: After reset, reqReady is 1, and rspValid and missReq are 0. All cache lines and translation entries are empty.
- R12: Each response asserts exactly one of rspHit, rspMiss and rspFault, for exactly one cycle. None of them is set without rspValid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request strobe, accepted while reqReady is high |
| reqWrite | input | 1 | 1 for a store, 0 for a load |
| reqVaddr | input | 32 | Virtual byte address |
| reqWdata | input | 32 | Store data |
| reqBe | input | 4 | Store byte enables |
| reqReady | output | 1 | Block idle and able to accept a request |
| tlbFillValid | input | 1 | Write one translation entry |
| tlbFillVpn | input | 20 | Virtual page number of the refill |
| tlbFillPfn | input | 20 | Physical frame number of the refill |
| tlbFillPteValid | input | 1 | Page-valid bit of the refill |
| tlbFillPerm | input | 2 | Permissions: bit 0 read, bit 1 write |
| lineFillValid | input | 1 | Line-fill beat from the next level |
| lineFillData | input | 512 | Full 64-byte line |
| missReq | output | 1 | Read miss outstanding |
| missPaddr | output | 32 | Physical line address of the miss |
| rspValid | output | 1 | Response strobe |
| rspHit | output | 1 | Access hit in the cache |
| rspMiss | output | 1 | Write missed, not allocated |
| rspFault | output | 1 | Page invalid or permission denied |
| rspPaddr | output | 32 | Translated physical byte address |
| rspRdata | output | 32 | Load data on a read hit |

## Verification
The bench sweeps all 64 sets, all 16 words of a line and all 15 byte-enable patterns, and predicts every address and data word arithmetically. A design that indexed with translated bits, or compared tags against virtual bits, would return the wrong word or miss where a hit is due.

Dedicated sequences exercise several corner cases:
- A fifth frame mapped onto a full set checks the victim choice. A wrong choice evicts a line that should still hit.
- A ninth page, and an in-place overwrite, check translation-buffer replacement. A design that duplicated entries or advanced the pointer on an overwrite would stall the wrong pages.
- Invalid pages and read-only or write-only pages must fault without a miss request.
- A write miss must leave the line unallocated.

// File: rtl/vipt_l1_pkg.sv
package vipt_l1_pkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_LOOK    = 2'd1,
    ST_TLBWAIT = 2'd2,
    ST_FILL    = 2'd3
  } ctrlState_t;

  // control -> datapath
  typedef struct packed {
    logic latchReq;
    logic lookup;
    logic commit;
    logic fillLine;
  } ctrlStrobe_t;

  // datapath -> control
  typedef struct packed {
    logic tlbHit;
    logic pteValid;
    logic permOk;
    logic cacheHit;
    logic isWrite;
  } lookStat_t;

endpackage

// File: rtl/vipt_l1_datapath.sv
module vipt_l1_datapath
  import vipt_l1_pkg::*;
#(
  parameter int unsigned VA_W       = 32,
  parameter int unsigned PA_W       = 32,
  parameter int unsigned WAYS       = 4,
  parameter int unsigned LINE_BYTES = 64,
  parameter int unsigned TLB_N      = 8
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  ctrlStrobe_t             strobe,
  output lookStat_t               stat,
  input  logic                    reqWrite,
  input  logic [VA_W-1:0]         reqVaddr,
  input  logic [31:0]             reqWdata,
  input  logic [3:0]              reqBe,
  input  logic                    tlbFillValid,
  input  logic [VA_W-13:0]        tlbFillVpn,
  input  logic [PA_W-13:0]        tlbFillPfn,
  input  logic                    tlbFillPteValid,
  input  logic [1:0]              tlbFillPerm,
  input  logic [LINE_BYTES*8-1:0] lineFillData,
  output logic [PA_W-1:0]         rspPaddr,
  output logic [31:0]             rspRdata,
  output logic [PA_W-1:0]         missPaddr
);
  localparam int unsigned PAGE_BITS = 12;
  localparam int unsigned OFF_BITS  = $clog2(LINE_BYTES);
  localparam int unsigned IDX_BITS  = PAGE_BITS - OFF_BITS;
  localparam int unsigned SETS      = 1 << IDX_BITS;
  localparam int unsigned WAY_W     = $clog2(WAYS);
  localparam int unsigned NLINES    = SETS * WAYS;
  localparam int unsigned LINE_BITS = LINE_BYTES * 8;
  localparam int unsigned WSEL_W    = OFF_BITS - 2;
  localparam int unsigned VPN_W     = VA_W - PAGE_BITS;
  localparam int unsigned PFN_W     = PA_W - PAGE_BITS;
  localparam int unsigned TLB_W     = $clog2(TLB_N);

  // latched request
  logic [VA_W-1:0] vaQ;
  logic            wrQ;
  logic [31:0]     wdQ;
  logic [3:0]      beQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vaQ <= '0; wrQ <= 1'b0; wdQ <= '0; beQ <= '0;
    end else if (strobe.latchReq) begin
      vaQ <= reqVaddr; wrQ <= reqWrite; wdQ <= reqWdata; beQ <= reqBe;
    end
  end

  logic [IDX_BITS-1:0] idxQ;
  logic [VPN_W-1:0]    vpnQ;
  logic [WSEL_W-1:0]   wordQ;
  assign idxQ  = vaQ[PAGE_BITS-1:OFF_BITS];
  assign vpnQ  = vaQ[VA_W-1:PAGE_BITS];
  assign wordQ = vaQ[OFF_BITS-1:2];

  // translation buffer
  logic             tlbOcc  [TLB_N];
  logic [VPN_W-1:0] tlbVpn  [TLB_N];
  logic [PFN_W-1:0] tlbPfn  [TLB_N];
  logic             tlbPte  [TLB_N];
  logic [1:0]       tlbPerm [TLB_N];
  logic [TLB_W-1:0] tlbPtr;
  logic [TLB_N-1:0] tlbHitVec, fillHitVec;

  for (genvar t = 0; t < TLB_N; t++) begin : g_tlbCam
    assign tlbHitVec[t]  = tlbOcc[t] && (tlbVpn[t] == vpnQ);
    assign fillHitVec[t] = tlbOcc[t] && (tlbVpn[t] == tlbFillVpn);
  end

  logic [PFN_W-1:0] pfnSel;
  logic             pteSel;
  logic [1:0]       permSel;
  logic [TLB_W-1:0] fillSlot;

  always_comb begin
    pfnSel = '0; pteSel = 1'b0; permSel = '0;
    fillSlot = tlbPtr;
    for (int t = 0; t < TLB_N; t++) begin
      if (tlbHitVec[t]) begin
        pfnSel = tlbPfn[t]; pteSel = tlbPte[t]; permSel = tlbPerm[t];
      end
      if (fillHitVec[t]) fillSlot = TLB_W'(t);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tlbPtr <= '0;
      for (int t = 0; t < TLB_N; t++) begin
        tlbOcc[t] <= 1'b0; tlbVpn[t] <= '0; tlbPfn[t] <= '0;
        tlbPte[t] <= 1'b0; tlbPerm[t] <= '0;
      end
    end else if (tlbFillValid) begin
      tlbOcc[fillSlot]  <= 1'b1;
      tlbVpn[fillSlot]  <= tlbFillVpn;
      tlbPfn[fillSlot]  <= tlbFillPfn;
      tlbPte[fillSlot]  <= tlbFillPteValid;
      tlbPerm[fillSlot] <= tlbFillPerm;
      if (fillHitVec == '0)
        tlbPtr <= (tlbPtr == TLB_W'(TLB_N - 1)) ? '0 : tlbPtr + 1'b1;
    end
  end

  // tag, valid and data arrays, indexed by {set, way}
  logic [PFN_W-1:0]     tagMem  [NLINES];
  logic [LINE_BITS-1:0] dataMem [NLINES];
  logic [NLINES-1:0]    lineValid;
  logic [WAYS-1:0]      setValid, wayHit;
  logic [WAY_W-1:0]     hitWay, victimWay, rrWay;

  for (genvar w = 0; w < WAYS; w++) begin : g_wayCmp
    assign setValid[w] = lineValid[{idxQ, WAY_W'(w)}];
    assign wayHit[w]   = setValid[w] && (tagMem[{idxQ, WAY_W'(w)}] == pfnSel);
  end

  always_comb begin
    hitWay    = '0;
    victimWay = rrWay;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (wayHit[w])    hitWay    = WAY_W'(w);
      if (!setValid[w]) victimWay = WAY_W'(w);
    end
  end

  logic [LINE_BITS-1:0] curLine, mergedLine;
  logic [31:0]          curWord;

  always_comb begin
    curLine    = dataMem[{idxQ, hitWay}];
    curWord    = curLine[int'(wordQ)*32 +: 32];
    mergedLine = curLine;
    for (int b = 0; b < 4; b++)
      if (beQ[b]) mergedLine[int'(wordQ)*32 + b*8 +: 8] = wdQ[b*8 +: 8];
  end

  always_ff @(posedge clk) begin
    if (strobe.fillLine) begin
      dataMem[{idxQ, victimWay}] <= lineFillData;
      tagMem[{idxQ, victimWay}]  <= pfnSel;
    end else if (strobe.commit && wrQ) begin
      dataMem[{idxQ, hitWay}] <= mergedLine;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lineValid <= '0;
      rrWay     <= '0;
    end else if (strobe.fillLine) begin
      lineValid[{idxQ, victimWay}] <= 1'b1;
      if (&setValid) rrWay <= rrWay + 1'b1;
    end
  end

  // response capture
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspPaddr <= '0; rspRdata <= '0; missPaddr <= '0;
    end else if (strobe.lookup) begin
      rspPaddr  <= {pfnSel, vaQ[PAGE_BITS-1:0]};
      rspRdata  <= curWord;
      missPaddr <= {pfnSel, idxQ, {OFF_BITS{1'b0}}};
    end
  end

  assign stat.tlbHit   = |tlbHitVec;
  assign stat.pteValid = pteSel;
  assign stat.permOk   = wrQ ? permSel[1] : permSel[0];
  assign stat.cacheHit = |wayHit;
  assign stat.isWrite  = wrQ;

  a_r10_single_tlb_match: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(tlbHitVec));

  a_r1_offset_passthru: assert property (@(posedge clk) disable iff (!rstN)
    strobe.lookup |=> rspPaddr[PAGE_BITS-1:0] == $past(vaQ[PAGE_BITS-1:0]));

  a_r6_replay_hits: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.fillLine && !tlbFillValid) |=> stat.cacheHit);

endmodule

// File: rtl/vipt_l1_ctrl.sv
module vipt_l1_ctrl
  import vipt_l1_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        tlbFillValid,
  input  logic        lineFillValid,
  input  lookStat_t   stat,
  output ctrlStrobe_t strobe,
  output logic        reqReady,
  output logic        missReq,
  output logic        rspValid,
  output logic        rspHit,
  output logic        rspMiss,
  output logic        rspFault
);
  ctrlState_t state, nextState;
  logic hitNext, missNext, faultNext;

  always_comb begin
    nextState = state;
    strobe    = '0;
    hitNext   = 1'b0;
    missNext  = 1'b0;
    faultNext = 1'b0;
    strobe.latchReq = (state == ST_IDLE) && reqValid;
    strobe.lookup   = (state == ST_LOOK);
    case (state)
      ST_IDLE: if (reqValid) nextState = ST_LOOK;
      ST_LOOK: begin
        if (!stat.tlbHit) begin
          nextState = tlbFillValid ? ST_LOOK : ST_TLBWAIT;
        end else if (!stat.pteValid || !stat.permOk) begin
          faultNext = 1'b1;
          nextState = ST_IDLE;
        end else if (stat.cacheHit) begin
          hitNext       = 1'b1;
          strobe.commit = 1'b1;
          nextState     = ST_IDLE;
        end else if (stat.isWrite) begin
          missNext  = 1'b1;
          nextState = ST_IDLE;
        end else begin
          nextState = ST_FILL;
        end
      end
      ST_TLBWAIT: if (tlbFillValid) nextState = ST_LOOK;
      ST_FILL: if (lineFillValid) begin
        strobe.fillLine = 1'b1;
        nextState       = ST_LOOK;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      rspValid <= 1'b0;
      rspHit   <= 1'b0;
      rspMiss  <= 1'b0;
      rspFault <= 1'b0;
    end else begin
      state    <= nextState;
      rspValid <= hitNext | missNext | faultNext;
      rspHit   <= hitNext;
      rspMiss  <= missNext;
      rspFault <= faultNext;
    end
  end

  assign reqReady = (state == ST_IDLE);
  assign missReq  = (state == ST_FILL);

  a_r12_one_outcome: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> $countones({rspHit, rspMiss, rspFault}) == 1);

  a_r12_no_stray_flag: assert property (@(posedge clk) disable iff (!rstN)
    !rspValid |-> !(rspHit || rspMiss || rspFault));

  a_r3_stall_silent: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_TLBWAIT) |-> !rspValid);

  a_r6_miss_held: assert property (@(posedge clk) disable iff (!rstN)
    (missReq && !lineFillValid) |=> missReq);

  a_r6_busy_on_miss: assert property (@(posedge clk) disable iff (!rstN)
    missReq |-> !reqReady);

endmodule

// File: rtl/vipt_l1_lookup.sv
module vipt_l1_lookup
  import vipt_l1_pkg::*;
#(
  parameter int unsigned VA_W       = 32,
  parameter int unsigned PA_W       = 32,
  parameter int unsigned WAYS       = 4,
  parameter int unsigned LINE_BYTES = 64,
  parameter int unsigned TLB_N      = 8
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    reqValid,
  input  logic                    reqWrite,
  input  logic [VA_W-1:0]         reqVaddr,
  input  logic [31:0]             reqWdata,
  input  logic [3:0]              reqBe,
  output logic                    reqReady,
  input  logic                    tlbFillValid,
  input  logic [VA_W-13:0]        tlbFillVpn,
  input  logic [PA_W-13:0]        tlbFillPfn,
  input  logic                    tlbFillPteValid,
  input  logic [1:0]              tlbFillPerm,
  input  logic                    lineFillValid,
  input  logic [LINE_BYTES*8-1:0] lineFillData,
  output logic                    missReq,
  output logic [PA_W-1:0]         missPaddr,
  output logic                    rspValid,
  output logic                    rspHit,
  output logic                    rspMiss,
  output logic                    rspFault,
  output logic [PA_W-1:0]         rspPaddr,
  output logic [31:0]             rspRdata
);
  ctrlStrobe_t strobe;
  lookStat_t   stat;

  vipt_l1_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid),
    .tlbFillValid(tlbFillValid), .lineFillValid(lineFillValid),
    .stat(stat), .strobe(strobe), .reqReady(reqReady), .missReq(missReq),
    .rspValid(rspValid), .rspHit(rspHit), .rspMiss(rspMiss), .rspFault(rspFault)
  );

  vipt_l1_datapath #(
    .VA_W(VA_W), .PA_W(PA_W), .WAYS(WAYS), .LINE_BYTES(LINE_BYTES), .TLB_N(TLB_N)
  ) i_datapath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .stat(stat),
    .reqWrite(reqWrite), .reqVaddr(reqVaddr), .reqWdata(reqWdata), .reqBe(reqBe),
    .tlbFillValid(tlbFillValid), .tlbFillVpn(tlbFillVpn), .tlbFillPfn(tlbFillPfn),
    .tlbFillPteValid(tlbFillPteValid), .tlbFillPerm(tlbFillPerm),
    .lineFillData(lineFillData), .rspPaddr(rspPaddr), .rspRdata(rspRdata),
    .missPaddr(missPaddr)
  );

endmodule

// File: tb/test_vipt_l1_lookup.sv
module test_vipt_l1_lookup;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         reqValid = 1'b0, reqWrite = 1'b0;
  logic [31:0]  reqVaddr = '0, reqWdata = '0;
  logic [3:0]   reqBe = '0;
  logic         reqReady;
  logic         tlbFillValid = 1'b0, tlbFillPteValid = 1'b0;
  logic [19:0]  tlbFillVpn = '0, tlbFillPfn = '0;
  logic [1:0]   tlbFillPerm = '0;
  logic         lineFillValid = 1'b0;
  logic [511:0] lineFillData = '0;
  logic         missReq, rspValid, rspHit, rspMiss, rspFault;
  logic [31:0]  missPaddr, rspPaddr, rspRdata;

  vipt_l1_lookup i_vipt_l1_lookup (.*);

  always #5 clk = ~clk;

  int nChk = 0, nFail = 0;
  bit finished = 0;
  logic [1:0] permTab [16];
  bit         pteTab  [16];

  logic gotHit, gotMiss, gotFault, stalled, sawMiss, done;
  logic [31:0] gotPaddr, gotData, sawMissPa;

  function automatic logic [19:0] pfnOf(input logic [19:0] vpn);
    return vpn + 20'h400;
  endfunction
  function automatic logic [31:0] paOf(input logic [31:0] va);
    return {pfnOf(va[31:12]), va[11:0]};
  endfunction
  function automatic logic [31:0] wordVal(input logic [31:0] pa);
    return {pa[31:2], 2'b00} ^ 32'h5A5A_0F0F;
  endfunction
  function automatic logic [511:0] mkLine(input logic [31:0] lpa);
    logic [511:0] l;
    for (int w = 0; w < 16; w++) l[w*32 +: 32] = wordVal({lpa[31:6], w[3:0], 2'b00});
    return l;
  endfunction
  function automatic logic [31:0] mkVa(input int vpn, input int set, input int word);
    return {vpn[19:0], set[5:0], word[3:0], 2'b00};
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic driveRefill(input logic [19:0] vpn);
    tlbFillValid    = 1'b1;
    tlbFillVpn      = vpn;
    tlbFillPfn      = pfnOf(vpn);
    tlbFillPteValid = pteTab[vpn[3:0]];
    tlbFillPerm     = permTab[vpn[3:0]];
  endtask

  task automatic refill(input logic [19:0] vpn);
    @(negedge clk);
    driveRefill(vpn);
    @(negedge clk);
    tlbFillValid = 1'b0;
  endtask

  task automatic doAccess(input logic wr, input logic [31:0] va,
                          input logic [31:0] wd, input logic [3:0] be);
    int  idle;
    bit  fillGiven;
    gotHit = 0; gotMiss = 0; gotFault = 0; stalled = 0; sawMiss = 0; done = 0;
    idle = 0; fillGiven = 0;
    @(negedge clk);
    if (!reqReady) begin nFail++; $display("FAIL R11 not ready at request actual=0 expected=1"); end
    reqValid = 1'b1; reqWrite = wr; reqVaddr = va; reqWdata = wd; reqBe = be;
    @(negedge clk);
    reqValid = 1'b0;
    for (int c = 0; c < 100 && !done; c++) begin
      if (rspValid) begin
        gotHit = rspHit; gotMiss = rspMiss; gotFault = rspFault;
        gotPaddr = rspPaddr; gotData = rspRdata; done = 1;
      end else begin
        if (missReq && !fillGiven) begin
          sawMiss = 1; sawMissPa = missPaddr;
          lineFillData = mkLine(missPaddr); lineFillValid = 1'b1; fillGiven = 1;
        end else if (!missReq) begin
          idle++;
          if (idle == 6 && !stalled) begin
            stalled = 1;
            chk("R3 ready low while stalled", reqReady, 1'b0);
            driveRefill(va[31:12]);
          end
        end
        @(negedge clk);
        lineFillValid = 1'b0; tlbFillValid = 1'b0;
      end
    end
    if (!done) begin nFail++; $display("FAIL R3 access never completed actual=none expected=response"); end
  endtask

  initial begin
    logic [31:0] va, expw, wd;
    for (int i = 0; i < 16; i++) begin permTab[i] = 2'b11; pteTab[i] = 1'b1; end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk("R11 reqReady", reqReady, 1'b1);
    chk("R11 rspValid", rspValid, 1'b0);
    chk("R11 missReq", missReq, 1'b0);

    // R3/R6/R1/R2: cold access, stall then miss then replayed hit
    va = mkVa(1, 5, 2);
    doAccess(1'b0, va, '0, '0);
    chk("R3 stalled on empty tlb", stalled, 1'b1);
    chk("R6 miss request seen", sawMiss, 1'b1);
    chk("R6 miss line address", sawMissPa, {pfnOf(20'd1), 6'd5, 6'd0});
    chk("R6 replay hit", gotHit, 1'b1);
    chk("R2 frame", gotPaddr, paOf(va));
    chk("R6 fill data", gotData, wordVal(paOf(va)));

    // R1: every word of the filled line
    for (int w = 0; w < 16; w++) begin
      va = mkVa(1, 5, w);
      doAccess(1'b0, va, '0, '0);
      chk("R1 word hit", {sawMiss, gotHit}, 2'b01);
      chk("R1 word data", gotData, wordVal(paOf(va)));
    end

    // R1/R6: every set
    for (int s = 0; s < 64; s++) begin
      va = mkVa(1, s, s % 16);
      doAccess(1'b0, va, '0, '0);
      chk("R6 miss only on cold set", sawMiss, (s != 5));
      chk("R1 offset bits", gotPaddr[11:0], va[11:0]);
      chk("R1 set data", gotData, wordVal(paOf(va)));
      chk("R12 single outcome", {gotHit, gotMiss, gotFault}, 3'b100);
    end

    // R7: all byte-enable patterns on one word
    va = mkVa(1, 0, 3);
    expw = wordVal(paOf(va));
    for (int be = 1; be < 16; be++) begin
      wd = 32'h1357_9BDF ^ (be * 32'h0101_0101);
      for (int b = 0; b < 4; b++) if (be[b]) expw[b*8 +: 8] = wd[b*8 +: 8];
      doAccess(1'b1, va, wd, be[3:0]);
      chk("R7 write hit", {gotHit, gotMiss, gotFault}, 3'b100);
      doAccess(1'b0, va, '0, '0);
      chk("R7 merged bytes", gotData, expw);
    end
    va = mkVa(1, 0, 4);
    doAccess(1'b0, va, '0, '0);
    chk("R7 neighbour word untouched", gotData, wordVal(paOf(va)));

    // R8: write miss does not allocate
    va = mkVa(2, 3, 2);
    doAccess(1'b1, va, 32'hCAFE_F00D, 4'hF);
    chk("R8 write miss outcome", {gotHit, gotMiss, gotFault}, 3'b010);
    chk("R8 no miss request", sawMiss, 1'b0);
    chk("R8 paddr", gotPaddr, paOf(va));
    doAccess(1'b0, va, '0, '0);
    chk("R8 line not allocated", sawMiss, 1'b1);
    chk("R8 read after", gotData, wordVal(paOf(va)));

    // R9: victim selection in set 10 (way 0 holds frame of page 1)
    for (int p = 2; p <= 5; p++) begin
      va = mkVa(p, 10, 1);
      doAccess(1'b0, va, '0, '0);
      chk("R9 fill needed", sawMiss, 1'b1);
      chk("R9 data", gotData, wordVal(paOf(va)));
    end
    for (int p = 2; p <= 4; p++) begin
      doAccess(1'b0, mkVa(p, 10, 1), '0, '0);
      chk("R9 survivor hits", {sawMiss, gotHit}, 2'b01);
    end
    doAccess(1'b0, mkVa(1, 10, 1), '0, '0);
    chk("R9 way 0 evicted", sawMiss, 1'b1);

    // R4: invalid page
    pteTab[7] = 1'b0;
    doAccess(1'b0, mkVa(7, 20, 0), '0, '0);
    chk("R4 fault", {gotHit, gotMiss, gotFault}, 3'b001);
    chk("R4 no miss request", sawMiss, 1'b0);

    // R5: permissions
    permTab[8] = 2'b01;
    doAccess(1'b1, mkVa(8, 20, 0), 32'h1, 4'hF);
    chk("R5 write to read-only", {gotHit, gotMiss, gotFault}, 3'b001);
    doAccess(1'b0, mkVa(8, 20, 0), '0, '0);
    chk("R5 read of read-only", gotHit, 1'b1);
    permTab[9] = 2'b10;
    doAccess(1'b0, mkVa(9, 21, 0), '0, '0);
    chk("R5 read of write-only", {gotFault, sawMiss}, 2'b10);
    doAccess(1'b1, mkVa(9, 21, 0), 32'h2, 4'hF);
    chk("R5 write to write-only", {gotHit, gotMiss, gotFault}, 3'b010);

    // R10: slots hold pages 1,2,3,4,5,7,8,9; pointer back at 0
    permTab[8] = 2'b11;
    refill(20'd8);
    doAccess(1'b1, mkVa(8, 20, 0), 32'h3, 4'hF);
    chk("R10 in-place overwrite no stall", stalled, 1'b0);
    chk("R10 new permission", {gotHit, gotFault}, 2'b10);
    refill(20'd10);
    doAccess(1'b0, mkVa(3, 10, 1), '0, '0);
    chk("R10 page 3 kept", stalled, 1'b0);
    doAccess(1'b0, mkVa(1, 5, 0), '0, '0);
    chk("R10 page 1 replaced first", stalled, 1'b1);
    doAccess(1'b0, mkVa(3, 10, 1), '0, '0);
    chk("R10 page 3 still present", stalled, 1'b0);
    doAccess(1'b0, mkVa(2, 10, 1), '0, '0);
    chk("R10 page 2 replaced next", stalled, 1'b1);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nFail++;
      $display("FAIL watchdog actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
      $finish;
    end
  end

endmodule